// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block serializes one asynchronous character onto an idle-high line. A start strobe captures a word of up to 9 bits, together with the frame settings. The block then sends a low start bit, the character bits and a high stop bit. It moves to the next bit on each pulse of an external bit-tick input. A one-cycle completion pulse marks the end of the frame. Baud-rate generation sits outside the block, and so do receive logic, queues and flow control.

A 2-bit length code fixes the character width. Turning parity on keeps that width and gives the last character slot to the parity bit. The top data bit of the word is then dropped from the line. A select input picks even or odd parity. A further option reverses the order of the data bits so that the most significant one is sent first. Every setting is sampled when a frame is accepted, and a strobe that arrives while a frame is in progress has no effect.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx` is 1, `busy` is 0 and `done` is 0; `bit_tick` pulses while idle leave the line high.
- R2: An accepted frame drives `tx` to 0 (start bit) on the clock edge that samples `start`, then presents each following bit on the edge that samples a `bit_tick` pulse. Each bit is held between ticks, and the last bit of the frame is a 1 (stop bit).
- R3: `wlen` selects the character width: 2'b00 gives 8 bits, 2'b01 gives 9 bits, 2'b10 gives 7 bits, and 2'b11 is treated exactly as 2'b00. A frame is therefore width+2 bits long.
- R4: With `par_en`=0, every character bit carries data: bit i of the character is `data_in[i]`, sent from bit 0 upward.
- R5: With `par_en`=1, only `data_in[W-2:0]` is sent, where W is the character width. The last character slot carries the parity bit, and `data_in[W-1]` and above never reach the line.
- R6: With `par_odd`=0, the parity bit makes the number of ones among the sent data bits plus parity even. With `par_odd`=1, it makes that number odd.
- R7: With `msb_first`=1, the sent data bits go out from the highest sent data bit down to `data_in[0]`. The parity bit, when enabled, still comes last.
- R8: `done` is 1 for exactly one cycle: the cycle after the clock edge that samples the tick ending the stop bit. `busy` falls on that same edge.
- R9: A `start` while `busy` is 1 is ignored. Changes to `data_in`, `wlen`, `par_en`, `par_odd` or `msb_first` during a frame do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| start | input | 1 | Request to send `data_in` |
| data_in | input | 9 | Word to send |
| wlen | input | 2 | Character width code |
| par_en | input | 1 | Parity replaces the top character slot |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| msb_first | input | 1 | Send data most significant bit first |
| tx | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
A vector table covers every length code, including the reserved one, in each parity and ordering combination. The words are chosen so that a dropped top bit, a parity computed over the full word instead of the sent bits, or a wrong polarity changes the captured character. A design that appended parity as an extra bit would give a frame one bit too long, and the bench would see `done` arriving a tick late. A strobe with a fully changed configuration is applied in the middle of a frame; a design that reloaded or re-read its settings would corrupt the remaining bits. Hold between ticks, idle ticks and the exact cycle of the `done` pulse are checked directly at the ports.

// File: rtl/uft_pkg.sv
package uft_pkg;

  typedef enum logic [1:0] {
    WL_BASE  = 2'b00,
    WL_WIDE  = 2'b01,
    WL_SHORT = 2'b10,
    WL_RSVD  = 2'b11
  } wlen_e;

  // Character width for a length code; the reserved code falls back to the base width.
  function automatic int unsigned char_bits(input logic [1:0] code, input int unsigned dw);
    case (wlen_e'(code))
      WL_WIDE:  return dw;
      WL_SHORT: return dw - 2;
      default:  return dw - 1;
    endcase
  endfunction

endpackage

// File: rtl/uft_frame_builder.sv
module uft_frame_builder #(
  parameter int DATA_W  = 9,
  parameter int FRAME_W = DATA_W + 2,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data_in,
  input  logic [1:0]         wlen,
  input  logic               par_en,
  input  logic               par_odd,
  input  logic               msb_first,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   last_idx
);

  logic [CNT_W-1:0]  n_char;
  logic [CNT_W-1:0]  n_data;
  logic [CNT_W-1:0]  idx;
  logic [DATA_W-1:0] chr;
  logic              par;

  always_comb begin
    n_char = CNT_W'(uft_pkg::char_bits(wlen, DATA_W));
    n_data = n_char - CNT_W'(par_en);
    chr    = '0;
    par    = par_odd;
    idx    = '0;
    // Data bits in line order; parity accumulates over exactly the bits sent.
    for (int i = 0; i < DATA_W; i++) begin
      if (CNT_W'(i) < n_data) begin
        idx    = msb_first ? (n_data - CNT_W'(1) - CNT_W'(i)) : CNT_W'(i);
        chr[i] = data_in[idx];
        par    = par ^ data_in[idx];
      end
    end
    if (par_en) chr[n_char - CNT_W'(1)] = par;
    // Frame: start bit, character, then ones (stop bit and padding).
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (CNT_W'(i) < n_char) frame[i+1] = chr[i];
    end
    last_idx = n_char + CNT_W'(1);
  end

endmodule

// File: rtl/uft_serializer.sv
module uft_serializer #(
  parameter int FRAME_W = 11,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   last_in,
  output logic               tx,
  output logic               busy,
  output logic               done
);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   last;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx    <= 1'b1;
      busy  <= 1'b0;
      done  <= 1'b0;
      shreg <= '1;
      cnt   <= '0;
      last  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (load) begin
          busy  <= 1'b1;
          tx    <= frame_in[0];
          shreg <= {1'b1, frame_in[FRAME_W-1:1]};
          cnt   <= '0;
          last  <= last_in;
        end
      end else if (bit_tick) begin
        if (cnt == last) begin
          busy <= 1'b0;
          done <= 1'b1;
          tx   <= 1'b1;
        end else begin
          tx    <= shreg[0];
          shreg <= {1'b1, shreg[FRAME_W-1:1]};
          cnt   <= cnt + CNT_W'(1);
        end
      end
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx); // R1

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !tx); // R2

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (busy && !bit_tick) |=> $stable(tx)); // R2

  AST_BUSY_KEEPS_FRAME: assert property (@(posedge clk) disable iff (rst)
    (busy && !bit_tick) |=> busy); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy) && $past(bit_tick))); // R8

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              start,
  input  logic [DATA_W-1:0] data_in,
  input  logic [1:0]        wlen,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              msb_first,
  output logic              tx,
  output logic              busy,
  output logic              done
);

  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   last_idx;

  uft_frame_builder #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_build (
    .data_in   (data_in),
    .wlen      (wlen),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .msb_first (msb_first),
    .frame     (frame),
    .last_idx  (last_idx)
  );

  // The serializer accepts a load only while idle, which drops strobes during a frame.
  uft_serializer #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_ser (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .load     (start),
    .frame_in (frame),
    .last_in  (last_idx),
    .tx       (tx),
    .busy     (busy),
    .done     (done)
  );

endmodule

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_tick = 1'b0;
  logic       start = 1'b0;
  logic [8:0] data_in = '0;
  logic [1:0] wlen = '0;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       msb_first = 1'b0;
  logic       tx, busy, done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  uart_frame_tx dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .start(start), .data_in(data_in),
    .wlen(wlen), .par_en(par_en), .par_odd(par_odd), .msb_first(msb_first),
    .tx(tx), .busy(busy), .done(done)
  );

  // {wlen, par_en, par_odd, msb_first, data, expected char (bit i = i-th sent), char width}
  localparam int NV = 12;
  localparam logic [26:0] VEC [NV] = '{
    {2'b00, 1'b0, 1'b0, 1'b0, 9'h0A5, 9'h0A5, 4'd8},
    {2'b01, 1'b0, 1'b0, 1'b0, 9'h1C3, 9'h1C3, 4'd9},
    {2'b10, 1'b0, 1'b0, 1'b0, 9'h1FF, 9'h07F, 4'd7},
    {2'b11, 1'b0, 1'b0, 1'b0, 9'h03C, 9'h03C, 4'd8},
    {2'b00, 1'b1, 1'b0, 1'b0, 9'h0F1, 9'h071, 4'd8},
    {2'b00, 1'b1, 1'b1, 1'b0, 9'h0F1, 9'h0F1, 4'd8},
    {2'b01, 1'b1, 1'b0, 1'b0, 9'h007, 9'h107, 4'd9},
    {2'b10, 1'b1, 1'b1, 1'b0, 9'h07E, 9'h03E, 4'd7},
    {2'b00, 1'b0, 1'b0, 1'b1, 9'h001, 9'h080, 4'd8},
    {2'b01, 1'b0, 1'b0, 1'b1, 9'h0B4, 9'h05A, 4'd9},
    {2'b10, 1'b1, 1'b0, 1'b1, 9'h003, 9'h030, 4'd7},
    {2'b00, 1'b1, 1'b1, 1'b1, 9'h081, 9'h040, 4'd8}
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Sends one frame, pacing ticks itself; poke_at >= 0 fires a disruptive strobe mid-frame.
  task automatic run_frame(input logic [1:0] wl, input logic pe, input logic po,
                           input logic mf, input logic [8:0] d, input int poke_at,
                           input string tag, input int exp_chr, input int exp_n);
    logic [15:0] fb;
    logic [8:0]  got;
    int          k;
    bit          held;
    fb = '1; got = '0; k = 0; held = 1'b1;
    @(negedge clk);
    wlen = wl; par_en = pe; par_odd = po; msb_first = mf; data_in = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && k < 16) begin
      fb[k] = tx;
      @(negedge clk);
      if (tx !== fb[k]) held = 1'b0;
      if (k == poke_at) begin
        start = 1'b1; data_in = ~d; wlen = 2'b01; par_en = ~pe; msb_first = ~mf; par_odd = ~po;
        @(negedge clk);
        start = 1'b0;
        if (tx !== fb[k] || !busy) held = 1'b0;
      end
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      k++;
    end
    for (int j = 0; j < 9; j++) if (j < k - 2) got[j] = fb[j+1];
    chk(tag, "character bits", int'(got), exp_chr);
    chk("R3", "frame length", k, exp_n + 2);
    chk("R2", "start bit", int'(fb[0]), 0);
    chk("R2", "stop bit", int'(fb[k-1]), 1);
    chk("R2", "bit held between ticks", int'(held), 1);
    chk("R8", "done after last tick", int'({done, busy, tx}), 3'b101);
    @(negedge clk);
    chk("R8", "done lasts one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset state {tx,busy,done}", int'({tx, busy, done}), 3'b100);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "idle ticks leave line high {tx,busy,done}", int'({tx, busy, done}), 3'b100);

    for (int v = 0; v < NV; v++) begin
      logic [26:0] e;
      string tag;
      e = VEC[v];
      tag = e[22] ? "R7" : (e[24] ? "R5/R6" : "R3/R4");
      run_frame(e[26:25], e[24], e[23], e[22], e[21:13], -1, tag, int'(e[12:4]), int'(e[3:0]));
    end

    // Strobe plus configuration change in the middle of a frame: no effect.
    run_frame(2'b00, 1'b0, 1'b0, 1'b0, 9'h0A5, 3, "R9", 9'h0A5, 8);
    // Parity over the sent bits only: top word bit set, odd count in the low 8 bits.
    run_frame(2'b01, 1'b1, 1'b0, 1'b0, 9'h1FE, -1, "R6", 9'h1FE, 9);

    repeat (4) @(negedge clk);
    chk("R1", "idle after frames {tx,busy,done}", int'({tx, busy, done}), 3'b100);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule